// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a 2 KB byte-wide serial EEPROM on a two-wire bus. It watches the clock line and the data line of the bus on the system clock, and answers a master through an open-drain data output: a single drive-low enable that the bus wiring resolves with a pull-up. The storage is an array of 2048 bytes, addressed by an 11-bit pointer that persists between transfers.

A transfer opens with a start condition and a control byte. The control byte carries a fixed device type code, the three upper pointer bits and a read/write flag. A write transfer then gives the low eight pointer bits, followed by any number of data bytes. These land in a 16-byte page, and the pointer wraps inside that page. A read transfer streams bytes from the current pointer across the whole array until the master withholds its acknowledge. A stop condition always returns the block to idle.

The bus inputs pass through two-flop synchronizers. All line events are taken from the synchronized values, so the bus clock must be a good deal slower than the system clock.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the output is released, and in idle any clock-line activity without a start condition draws no acknowledge.
- R2: SDA falling while SCL is high is a start, which makes the block expect a control byte (also in the middle of a transfer). SDA rising while SCL is high is a stop, which sends the block to idle with the line released.
- R3: Bits are taken on the SCL rising edge, most significant bit first. The output changes only after an SCL falling edge or a start/stop condition.
- R4: The control byte has the layout {type[3:0], hi[2:0], rw}. A type other than 4'b1010 draws no acknowledge and sends the block to idle, so later bytes are not acknowledged either.
- R5: The hi field of an accepted control byte replaces pointer bits 10:8, for both reads and writes.
- R6: Every received byte is acknowledged. The block drives low from the falling edge after the eighth bit until the next falling edge. With rw = 0, the next byte sets pointer bits 7:0, and each byte after that is stored at the pointer.
- R7: After each stored byte, only pointer bits 3:0 increment, wrapping within the 16-byte page. Bits 10:4 stay unchanged.
- R8: With rw = 1, the byte at the pointer is sent right after the control byte's acknowledge. Each byte loaded for sending advances the pointer by one, modulo 2048.
- R9: After each sent byte the line is released for the acknowledge bit. A low level from the master brings the next byte, and a high level sends the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as resolved on the wire |
| sda_drive_low_o | output | 1 | Pull the data line low when 1; release it when 0 |

## Verification
Single-byte writes followed by random reads with a repeated start are run over a table of addresses and data patterns. The patterns include the first and last array locations, asymmetric bit patterns that expose a reversed bit order, and upper address bits that only the control byte can supply. A write stream of 18 bytes that starts two bytes below a page end separates page wrapping from a plain increment. A sequential read across that page boundary and across the top of the array shows that reads do not wrap in the page. Invalid control bytes, a stop in the middle of a write, clocking without a start, and a master that withholds its acknowledge each show that the block stays silent afterwards.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_DATA,
    ST_SEND,
    ST_MACK
  } twi_state_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_line_events.sv
module twi_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int          ADDR_W      = 11,
  parameter int          PAGE_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_low_o
);
  import twi_eeprom_pkg::*;

  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;

  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall_evt, start_evt, stop_evt;
  twi_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] shreg, tx_q, rd_data;
  logic [3:0]        bit_cnt, tx_cnt;
  logic [1:0]        fetch_q;
  logic              wr_en;

  twi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  twi_line_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall_evt),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign wr_en = scl_fall_evt && (state == ST_DATA) && (bit_cnt == 4'd8);

  eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (shreg),
    .raddr (ptr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      ptr             <= '0;
      shreg           <= '0;
      tx_q            <= '0;
      bit_cnt         <= '0;
      tx_cnt          <= '0;
      fetch_q         <= '0;
      sda_drive_low_o <= 1'b0;
    end else begin
      fetch_q <= {fetch_q[0], 1'b0};
      // the read port follows ptr one cycle late; the byte is taken two cycles after the request
      if (fetch_q[1]) begin
        tx_q <= rd_data;
        ptr  <= ptr + ADDR_W'(1);
      end

      if (stop_evt) begin
        state           <= ST_IDLE;
        sda_drive_low_o <= 1'b0;
      end else if (start_evt) begin
        state           <= ST_CTRL;
        bit_cnt         <= '0;
        sda_drive_low_o <= 1'b0;
      end else if (scl_rise && state != ST_IDLE) begin
        if (state == ST_MACK) begin
          if (sda_s) begin
            state <= ST_IDLE;
          end else begin
            state      <= ST_SEND;
            tx_cnt     <= '0;
            fetch_q[0] <= 1'b1;
          end
        end else if (state != ST_SEND && !sda_drive_low_o) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
      end else if (scl_fall_evt && state != ST_IDLE) begin
        if (bit_cnt == 4'd8) begin
          bit_cnt         <= '0;
          sda_drive_low_o <= 1'b1;
          case (state)
            ST_CTRL: begin
              if (shreg[7:4] != DEV_TYPE) begin
                state           <= ST_IDLE;
                sda_drive_low_o <= 1'b0;
              end else begin
                ptr[ADDR_W-1:BYTE_W] <= shreg[HI_W:1];
                if (shreg[0]) begin
                  state      <= ST_SEND;
                  tx_cnt     <= '0;
                  fetch_q[0] <= 1'b1;
                end else begin
                  state <= ST_ADDR;
                end
              end
            end
            ST_ADDR: begin
              ptr[BYTE_W-1:0] <= shreg;
              state           <= ST_DATA;
            end
            default: begin
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
            end
          endcase
        end else if (state == ST_SEND) begin
          if (tx_cnt == 4'd8) begin
            state           <= ST_MACK;
            sda_drive_low_o <= 1'b0;
          end else begin
            sda_drive_low_o <= ~tx_q[BYTE_W-1];
            tx_q            <= {tx_q[BYTE_W-2:0], 1'b0};
            tx_cnt          <= tx_cnt + 4'd1;
          end
        end else begin
          sda_drive_low_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_drive_low_o,
  input twi_state_t        state,
  input logic [ADDR_W-1:0] ptr,
  input logic              wr_en,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_fall_evt,
  input logic              fetch_done
);
  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !sda_drive_low_o);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!sda_drive_low_o && state == ST_IDLE));

  // R3
  drive_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !(scl_fall_evt || start_evt || stop_evt) |=> $stable(sda_drive_low_o));

  // R6
  store_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> sda_drive_low_o);

  // R7
  page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]) &&
               ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + PAGE_W'(1)));

  // R8
  read_advance_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> ptr == $past(ptr) + ADDR_W'(1));
endmodule

bind twi_eeprom_slave twi_eeprom_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .sda_drive_low_o (sda_drive_low_o),
  .state           (state),
  .ptr             (ptr),
  .wr_en           (wr_en),
  .start_evt       (start_evt),
  .stop_evt        (stop_evt),
  .scl_fall_evt    (scl_fall_evt),
  .fetch_done      (fetch_q[1])
);

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
  localparam int HALF = 12;
  localparam int NVEC = 6;
  // {address, data}
  localparam logic [18:0] VEC [NVEC] = '{
    {11'h000, 8'h5A}, {11'h001, 8'h81}, {11'h7FF, 8'hC3},
    {11'h501, 8'h3C}, {11'h130, 8'hE7}, {11'h2A4, 8'h01}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic drv;
  logic bus;
  logic [7:0] model [2048];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign bus = sda_m & ~drv;

  twi_eeprom_slave uut (
    .clk             (clk),
    .rst             (rst),
    .scl_i           (scl),
    .sda_i           (bus),
    .sda_drive_low_o (drv)
  );

  task automatic half();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half();
    sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl = 1'b1; half(); scl = 1'b0; half();
    end
    sda_m = 1'b1; half(); scl = 1'b1; half();
    acked = !bus;
    scl = 1'b0; half();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scl = 1'b1; half(); d = {d[6:0], bus}; scl = 1'b0; half();
    end
    sda_m = !mack; half(); scl = 1'b1; half(); scl = 1'b0; half();
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [10:0] a);
    bit ack;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack);
    check(ack, "R6 control ack", ack, 1);
    send_byte(a[7:0], ack);
    check(ack, "R6 address ack", ack, 1);
  endtask

  task automatic write_run(input logic [10:0] a, input int n, input logic [7:0] first);
    bit ack;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i), ack);
      check(ack, "R6 data ack", ack, 1);
      model[{a[10:4], 4'(a[3:0] + 4'(i))}] = first + 8'(i);   // R7 page wrap in model
    end
    bus_stop();
  endtask

  task automatic read_run(input logic [10:0] a, input int n);
    bit ack;
    logic [7:0] d;
    set_addr(a);
    bus_start();   // R2 repeated start
    send_byte({4'b1010, a[10:8], 1'b1}, ack);
    check(ack, "R8 read control ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      check(d == model[11'(a + 11'(i))], "R8 R9 read data", d, model[11'(a + 11'(i))]);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    half();
    check(drv == 1'b0, "R1 reset released", drv, 0);

    // R1: clocking without a start
    send_byte(8'hA0, ack);
    check(!ack, "R1 idle ignores clocks", ack, 0);
    bus_stop();

    // R3 R5 R6 R8: vector table
    for (int v = 0; v < NVEC; v++) begin
      write_run(VEC[v][18:8], 1, VEC[v][7:0]);
      read_run(VEC[v][18:8], 1);
    end

    // R4: bad device type
    bus_start();
    send_byte(8'hB0, ack);
    check(!ack, "R4 bad type no ack", ack, 0);
    send_byte(8'hA0, ack);
    check(!ack, "R4 stays idle", ack, 0);
    bus_stop();

    // R2: stop in the middle of a write
    set_addr(11'h040);
    bus_stop();
    send_byte(8'h77, ack);
    check(!ack, "R2 stop to idle", ack, 0);
    bus_stop();

    // R7: page wrap on write, then read across the page end
    write_run(11'h12E, 18, 8'h40);
    read_run(11'h120, 17);
    check(model[11'h120] == 8'h42 && model[11'h12E] == 8'h50, "R7 model wrap",
          model[11'h12E], 8'h50);

    // R8: read across the top of the array
    read_run(11'h7FF, 2);

    // R5 R8: current-pointer read with new upper bits (pointer now 0x001)
    bus_start();
    send_byte(8'hAB, ack);
    check(ack, "R5 read control ack", ack, 1);
    recv_byte(1'b0, d);
    check(d == model[11'h501], "R5 upper bits from control", d, model[11'h501]);
    bus_stop();

    // R9: master NACK ends the read
    write_run(11'h002, 1, 8'h00);
    bus_start();
    send_byte(8'hA1, ack);
    check(ack, "R9 read control ack", ack, 1);
    recv_byte(1'b0, d);
    recv_byte(1'b0, d);
    check(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    bus_stop();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule